// File: doc/BRIEF.md
# Synchronous Burst SRAM with Pipelined Deselect

This block is a synthesizable model of a synchronous burst static RAM. Each word holds four 9-bit byte lanes. All commands are sampled on the rising clock edge: two address strobes, an advance input, three chip enables and the write controls. There is one strobe for processor-style starts and one for controller-style starts. The write controls are a global write, a byte-write enable and one strobe per lane. The output enable acts without reference to the clock. Read data leaves on a bus modelled as tri-state: `rdata` reads as zero whenever `rdata_drive` is low.

A two-bit burst counter steps through four words in either linear or interleaved order, starting from an address loaded by a strobe. A static mode input selects how read data is timed:

- In flow-through timing, data leaves straight from the array read register.
- In registered timing, data passes through one more output register.

A deselect travels down the same output pipeline as a read. The drivers therefore stay on for the reads already in flight and turn off only when the deselect slot reaches the end of the pipeline.

Control is a three-state machine:

- States: `ST_DESEL` (no burst open), `ST_READ` (last access was a read) and `ST_WRITE` (last access was a write).
- Transitions: start read and continue read lead to `ST_READ`, start write and continue write lead to `ST_WRITE`, and deselect leads to `ST_DESEL`.
- The idle command, with no strobe while in `ST_DESEL`, holds the state.

Top module: `sync_burst_sram`

## Requirements
- R1: A strobe starts an access only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A controller strobe with any enable inactive is a deselect. A processor strobe has no effect while `ce1_n`=1.
- R2: A processor strobe with `ce1_n`=0 starts a read whatever the write controls, and it wins over a simultaneous controller strobe. A controller strobe starts a read or a write according to R3.
- R3: Write lane mask: `gw_n`=0 writes all four lanes. Otherwise `bwe_n`=0 writes lane i (data bits 9i+8..9i) for each `byte_we_n[i]`=0. Any other combination is a read.
- R4: With no strobe while a burst is open, `adv_n`=0 moves to the next burst address and `adv_n`=1 repeats the current one. Burst step n≥1 uses low bits (start+n) mod 4 when `linear_order`=1 and start XOR (n mod 4) when `linear_order`=0. The other address bits never change, and the fifth step wraps to the start address.
- R5: Write data is committed to the array on the edge that samples its address. A write slot never drives the outputs, and a later read returns the new lanes.
- R6: Read data is driven after the first edge following the address when `pipe_mode`=0, and after the second edge when `pipe_mode`=1.
- R7: A deselect occupies a pipeline slot like a read. Data already in flight keeps being driven, and the drivers turn off when the deselect slot reaches the output.
- R8: `oe_n`=1 turns the drivers off at once, without waiting for a clock edge. `oe_n`=0 drives only slots that carry read data. `rdata` is zero whenever `rdata_drive` is 0.
- R9: An asynchronous low `rst_n` empties the output pipeline (no drive) and returns to `ST_DESEL`. The array contents are kept.
- R10: Continue cycles without a strobe while in `ST_DESEL` perform no access. They neither write nor drive, even with `gw_n`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_mode | input | 1 | Static: 1 registered output, 0 flow-through |
| linear_order | input | 1 | Static: 1 linear burst, 0 interleaved burst |
| addr | input | ADDR_W | Word address loaded by a strobe |
| proc_strobe_n | input | 1 | Processor-style start strobe, active low, read only |
| ctrl_strobe_n | input | 1 | Controller-style start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable, active low; also masks the processor strobe |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| byte_we_n | input | LANES | Per-lane write strobes, active low |
| wdata | input | LANES*LANE_W | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | LANES*LANE_W | Read data, zero when not driven |
| rdata_drive | output | 1 | Output drivers on |

## Verification
The assertions check several rules on every cycle:

- A processor strobe never writes.
- `ce1_n` high with a controller strobe never writes.
- Burst advance keeps the upper address bits.
- Read slots reach the drivers after exactly one or two edges, depending on the mode.
- Write slots and deselect slots never drive.

Only the bench scenarios can show the data itself: that lane masks land in the right bytes, that linear and interleaved sequences wrap, and that the output enable acts between edges. They also show that the array contents survive a reset, against a reference array and a reference pipeline.

// File: rtl/sram_pkg.sv
package sram_pkg;

    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } bst_state_t;

    typedef enum logic [2:0] {
        CMD_IDLE     = 3'd0,
        CMD_DESEL    = 3'd1,
        CMD_START_RD = 3'd2,
        CMD_START_WR = 3'd3,
        CMD_CONT_RD  = 3'd4,
        CMD_CONT_WR  = 3'd5
    } bcmd_t;

endpackage

// File: rtl/sram_burst_addr.sv
module sram_burst_addr #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              linear_order,
    input  logic              load,
    input  logic              advance,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] acc_addr
);
    logic [ADDR_W-1:0] base_q;
    logic [1:0]        cnt_q;
    logic [1:0]        step;

    function automatic logic [1:0] burst_order(input logic [1:0] lo, input logic [1:0] n,
                                               input logic lin);
        return lin ? (lo + n) : (lo ^ n);
    endfunction

    assign step = advance ? (cnt_q + 2'd1) : cnt_q;

    always_comb begin
        if (load) acc_addr = ext_addr;
        else      acc_addr = {base_q[ADDR_W-1:2], burst_order(base_q[1:0], step, linear_order)};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            base_q <= ext_addr;
            cnt_q  <= '0;
        end else if (advance) begin
            cnt_q  <= cnt_q + 2'd1;
        end
    end

    // R4: advancing a burst never touches the upper address bits
    assert_burst_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && $past(rst_n)) |-> (acc_addr[ADDR_W-1:2] == $past(acc_addr[ADDR_W-1:2])));

endmodule

// File: rtl/sram_write_decode.sv
module sram_write_decode #(
    parameter int LANES = 4
) (
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] byte_we_n,
    output logic [LANES-1:0] lane_we,
    output logic             wr_any
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_we[i] = !gw_n || (!bwe_n && !byte_we_n[i]);
    end

    assign wr_any = |lane_we;

endmodule

// File: rtl/sram_out_pipe.sv
module sram_out_pipe #(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe_mode,
    input  logic              issue_rd,
    input  logic [DATA_W-1:0] rd_word,
    input  logic              oe_n,
    output logic [DATA_W-1:0] q,
    output logic              q_drive
);
    logic              s1_drv, s2_drv;
    logic [DATA_W-1:0] s1_dat, s2_dat;
    logic              sel_drv;
    logic [DATA_W-1:0] sel_dat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_drv <= 1'b0;
            s2_drv <= 1'b0;
            s1_dat <= '0;
            s2_dat <= '0;
        end else begin
            s1_drv <= issue_rd;
            s1_dat <= issue_rd ? rd_word : '0;
            s2_drv <= s1_drv;
            s2_dat <= s1_dat;
        end
    end

    always_comb begin
        sel_drv = pipe_mode ? s2_drv : s1_drv;
        sel_dat = pipe_mode ? s2_dat : s1_dat;
        q_drive = sel_drv && !oe_n;
        q       = q_drive ? sel_dat : '0;
    end

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
    import sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pipe_mode,
    input  logic                    linear_order,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    proc_strobe_n,
    input  logic                    ctrl_strobe_n,
    input  logic                    adv_n,
    input  logic                    ce1_n,
    input  logic                    ce2,
    input  logic                    ce3_n,
    input  logic                    gw_n,
    input  logic                    bwe_n,
    input  logic [LANES-1:0]        byte_we_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    oe_n,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_drive
);
    localparam int DATA_W = LANES * LANE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    bst_state_t        state_q, state_d;
    bcmd_t             cmd;
    logic [LANES-1:0]  lane_we;
    logic              wr_any;
    logic              chip_en;
    logic              load, advance, mem_we, issue_rd;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_word;

    sram_write_decode #(.LANES(LANES)) u_wdec (
        .gw_n      (gw_n),
        .bwe_n     (bwe_n),
        .byte_we_n (byte_we_n),
        .lane_we   (lane_we),
        .wr_any    (wr_any)
    );

    assign chip_en = !ce1_n && ce2 && !ce3_n;

    // command decode from strobes, enables and current state
    always_comb begin
        cmd = CMD_IDLE;
        if (!proc_strobe_n && !ce1_n) begin
            cmd = chip_en ? CMD_START_RD : CMD_DESEL;
        end else if (!ctrl_strobe_n) begin
            if (!chip_en)    cmd = CMD_DESEL;
            else if (wr_any) cmd = CMD_START_WR;
            else             cmd = CMD_START_RD;
        end else begin
            unique case (state_q)
                ST_DESEL:          cmd = CMD_IDLE;
                ST_READ, ST_WRITE: cmd = wr_any ? CMD_CONT_WR : CMD_CONT_RD;
                default:           cmd = CMD_IDLE;
            endcase
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (cmd)
            CMD_DESEL:                 state_d = ST_DESEL;
            CMD_START_RD, CMD_CONT_RD: state_d = ST_READ;
            CMD_START_WR, CMD_CONT_WR: state_d = ST_WRITE;
            CMD_IDLE:                  state_d = state_q;
            default:                   state_d = ST_DESEL;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_DESEL;
        else        state_q <= state_d;
    end

    // machine outputs
    always_comb begin
        load     = 1'b0;
        advance  = 1'b0;
        mem_we   = 1'b0;
        issue_rd = 1'b0;
        unique case (cmd)
            CMD_START_RD: begin load = rst_n; issue_rd = rst_n; end
            CMD_START_WR: begin load = rst_n; mem_we   = rst_n; end
            CMD_CONT_RD:  begin advance = rst_n && !adv_n; issue_rd = rst_n; end
            CMD_CONT_WR:  begin advance = rst_n && !adv_n; mem_we   = rst_n; end
            CMD_IDLE, CMD_DESEL: ;
            default: ;
        endcase
    end

    sram_burst_addr #(.ADDR_W(ADDR_W)) u_burst (
        .clk          (clk),
        .rst_n        (rst_n),
        .linear_order (linear_order),
        .load         (load),
        .advance      (advance),
        .ext_addr     (addr),
        .acc_addr     (acc_addr)
    );

    // storage array, lane-masked write on the address edge
    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (mem_we && lane_we[i])
                mem[acc_addr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
        end
    end

    assign rd_word = mem[acc_addr];

    sram_out_pipe #(.DATA_W(DATA_W)) u_opipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .pipe_mode (pipe_mode),
        .issue_rd  (issue_rd),
        .rd_word   (rd_word),
        .oe_n      (oe_n),
        .q         (rdata),
        .q_drive   (rdata_drive)
    );

    // R1: ce1_n high blocks any write from a controller strobe
    assert_ce1_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ce1_n && !ctrl_strobe_n) |-> !mem_we);

    // R2: a processor-strobe start never writes
    assert_proc_read_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_strobe_n && !ce1_n) |-> !mem_we);

    // R6: flow-through read reaches the drivers one edge later
    assert_flow_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && $past(issue_rd) && !oe_n) |-> rdata_drive);

    // R6: registered read reaches the drivers two edges later
    assert_pipe_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && $past(issue_rd, 2) && !oe_n) |-> rdata_drive);

    // R5: a write slot never drives in flow-through timing
    assert_write_hiz_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && $past(mem_we)) |-> !rdata_drive);

    // R7: a deselect slot turns the drivers off when it reaches the output
    assert_desel_depth_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && $past(cmd == CMD_DESEL, 2)) |-> !rdata_drive);

endmodule

// File: tb/sync_burst_sram_tb.sv
module sync_burst_sram_tb_top;
    localparam int AW = 8;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int DW = NL * LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pipe_mode = 1'b1, linear_order = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          proc_strobe_n = 1'b1, ctrl_strobe_n = 1'b1, adv_n = 1'b1;
    logic          ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
    logic          gw_n = 1'b1, bwe_n = 1'b1;
    logic [NL-1:0] byte_we_n = '1;
    logic [DW-1:0] wdata = '0;
    logic          oe_n = 1'b0;
    logic [DW-1:0] rdata;
    logic          rdata_drive;

    int n_checks = 0;
    int n_fails  = 0;
    string cur_req = "R9";

    // reference model state
    logic [DW-1:0] ref_mem [1 << AW];
    int            m_state;           // 0 deselected, 1 read, 2 write
    logic [AW-1:0] m_base;
    logic [1:0]    m_cnt;
    logic [DW:0]   e1, e2;            // {drive, data}

    always #10 clk = ~clk;

    sync_burst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .linear_order(linear_order),
        .addr(addr), .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
        .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n),
        .bwe_n(bwe_n), .byte_we_n(byte_we_n), .wdata(wdata), .oe_n(oe_n),
        .rdata(rdata), .rdata_drive(rdata_drive)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    task automatic check(input string req, input logic [DW:0] act, input logic [DW:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [NL-1:0] lane_mask(input logic g, input logic b, input logic [NL-1:0] s);
        logic [NL-1:0] m;
        for (int i = 0; i < NL; i++) m[i] = !g || (!b && !s[i]);
        return m;
    endfunction

    function automatic logic [AW-1:0] burst_addr(input logic [AW-1:0] base, input logic [1:0] n,
                                                 input logic lin);
        logic [1:0] lo;
        lo = lin ? base[1:0] + n : base[1:0] ^ n;
        return {base[AW-1:2], lo};
    endfunction

    function automatic logic [DW:0] expected_out();
        logic [DW:0] s;
        s = pipe_mode ? e2 : e1;
        if (!s[DW] || oe_n) return '0;
        return s;
    endfunction

    task automatic idle_inputs();
        proc_strobe_n = 1'b1; ctrl_strobe_n = 1'b1; adv_n = 1'b1;
        ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
        gw_n = 1'b1; bwe_n = 1'b1; byte_we_n = '1; oe_n = 1'b0;
    endtask

    // one clock: model the command, step the edge, check at the falling edge
    task automatic tick();
        int            cmd;   // 0 idle 1 desel 2 start rd 3 start wr 4 cont rd 5 cont wr
        logic          en;
        logic [NL-1:0] m;
        logic [AW-1:0] a;
        logic [DW-1:0] nv;
        en = !ce1_n && ce2 && !ce3_n;
        m  = lane_mask(gw_n, bwe_n, byte_we_n);
        if (!proc_strobe_n && !ce1_n)  cmd = en ? 2 : 1;
        else if (!ctrl_strobe_n)       cmd = en ? ((m != 0) ? 3 : 2) : 1;
        else if (m_state == 0)         cmd = 0;
        else                           cmd = (m != 0) ? 5 : 4;
        if (cmd == 2 || cmd == 3) a = addr;
        else a = burst_addr(m_base, m_cnt + ((!adv_n) ? 2'd1 : 2'd0), linear_order);
        @(posedge clk);
        e2 = e1;
        e1 = (cmd == 2 || cmd == 4) ? {1'b1, ref_mem[a]} : '0;
        if (cmd == 3 || cmd == 5) begin
            nv = ref_mem[a];
            for (int i = 0; i < NL; i++) if (m[i]) nv[i*LW +: LW] = wdata[i*LW +: LW];
            ref_mem[a] = nv;
        end
        if (cmd == 2 || cmd == 3) begin m_base = addr; m_cnt = 2'd0; end
        else if ((cmd == 4 || cmd == 5) && !adv_n) m_cnt = m_cnt + 2'd1;
        if (cmd == 1) m_state = 0;
        else if (cmd == 2 || cmd == 4) m_state = 1;
        else if (cmd == 3 || cmd == 5) m_state = 2;
        @(negedge clk);
        check(cur_req, {rdata_drive, rdata}, expected_out());
    endtask

    task automatic do_reset(input logic mode, input logic lin);
        @(negedge clk);
        rst_n = 1'b0;
        idle_inputs();
        pipe_mode = mode; linear_order = lin;
        m_state = 0; m_base = '0; m_cnt = '0; e1 = '0; e2 = '0;
        repeat (2) @(negedge clk);
        check("R9", {rdata_drive, rdata}, '0);
        rst_n = 1'b1;
    endtask

    task automatic start(input logic [AW-1:0] a, input logic wr, input logic [DW-1:0] d);
        idle_inputs();
        ctrl_strobe_n = 1'b0; addr = a; gw_n = !wr; wdata = d;
        tick();
    endtask

    task automatic cont(input logic adv);
        idle_inputs();
        adv_n = !adv;
        tick();
    endtask

    initial begin
        logic [63:0] rv;
        void'($urandom(32'd2024));
        for (int i = 0; i < (1 << AW); i++) ref_mem[i] = '0;
        // R9: reset state
        do_reset(1'b1, 1'b1);

        // R5: fill every word with a known pattern; write slots never drive
        cur_req = "R5";
        for (int i = 0; i < (1 << AW); i++) start(AW'(i), 1'b1, {4'(i), 32'hA5C3_0000 | 32'(i * 7)});
        start(8'h10, 1'b0, '0);   // R5: read back a freshly written word
        cont(1'b0); cont(1'b0);

        // R6: flow-through latency, single reads then deselect
        do_reset(1'b0, 1'b1);
        cur_req = "R6";
        start(8'h21, 1'b0, '0); start(8'h22, 1'b0, '0);
        idle_inputs(); ctrl_strobe_n = 1'b0; ce2 = 1'b0; tick();   // R7 deselect
        cont(1'b0); cont(1'b0);

        // R8: asynchronous output enable between edges
        cur_req = "R8";
        start(8'h33, 1'b0, '0);
        oe_n = 1'b1; #1;
        check("R8", {rdata_drive, rdata}, '0);
        oe_n = 1'b0; #1;
        check("R8", {rdata_drive, rdata}, {1'b1, ref_mem[8'h33]});

        // R9: array survives reset; R6 registered latency
        do_reset(1'b1, 1'b1);
        cur_req = "R6";
        start(8'h40, 1'b0, '0); start(8'h41, 1'b0, '0); start(8'h42, 1'b0, '0);
        // R7: deselect after reads keeps drivers on for in-flight data
        cur_req = "R7";
        idle_inputs(); ctrl_strobe_n = 1'b0; ce3_n = 1'b1; tick();
        cont(1'b0); cont(1'b0);

        // R4: linear burst with suspend and wrap
        cur_req = "R4";
        start(8'h56, 1'b0, '0);
        cont(1'b1); cont(1'b0); cont(1'b1); cont(1'b1); cont(1'b1); cont(1'b0);
        // R4: interleaved burst
        do_reset(1'b1, 1'b0);
        cur_req = "R4";
        start(8'h67, 1'b0, '0);
        cont(1'b1); cont(1'b1); cont(1'b1); cont(1'b1); cont(1'b1);
        // R4: burst write beats then read back
        start(8'h79, 1'b1, 36'h1_1111_1111);
        idle_inputs(); adv_n = 1'b0; gw_n = 1'b0; wdata = 36'h2_2222_2222; tick();
        start(8'h79, 1'b0, '0); cont(1'b1); cont(1'b0); cont(1'b0);

        // R3: lane-masked writes, and byte strobes without enable read
        cur_req = "R3";
        idle_inputs(); ctrl_strobe_n = 1'b0; addr = 8'h81; bwe_n = 1'b0; byte_we_n = 4'b1010;
        wdata = 36'hF_FFFF_FFFF; tick();
        idle_inputs(); ctrl_strobe_n = 1'b0; addr = 8'h82; bwe_n = 1'b1; byte_we_n = 4'b0000;
        wdata = 36'h0_0000_0000; tick();
        idle_inputs(); ctrl_strobe_n = 1'b0; addr = 8'h83; gw_n = 1'b0; bwe_n = 1'b1;
        wdata = 36'h9_8765_4321; tick();
        start(8'h81, 1'b0, '0); start(8'h82, 1'b0, '0); start(8'h83, 1'b0, '0); cont(1'b0);

        // R2: processor strobe reads despite global write
        cur_req = "R2";
        idle_inputs(); proc_strobe_n = 1'b0; ctrl_strobe_n = 1'b0; addr = 8'h90; gw_n = 1'b0;
        wdata = '1; tick();
        cont(1'b0); cont(1'b0);
        start(8'h90, 1'b0, '0); cont(1'b0); cont(1'b0);

        // R1: ce1_n high masks processor strobe, burst continues
        cur_req = "R1";
        start(8'hA4, 1'b0, '0);
        idle_inputs(); proc_strobe_n = 1'b0; ce1_n = 1'b1; addr = 8'h10; adv_n = 1'b0; tick();
        idle_inputs(); ctrl_strobe_n = 1'b0; ce1_n = 1'b1; gw_n = 1'b0; addr = 8'hA4; tick();
        cont(1'b0); cont(1'b0);

        // R10: no strobe while deselected: no write, no drive
        cur_req = "R10";
        idle_inputs(); gw_n = 1'b0; adv_n = 1'b0; wdata = '1; tick(); tick();
        start(8'hA4, 1'b0, '0); start(8'hA5, 1'b0, '0); cont(1'b0); cont(1'b0);

        // R2: constrained random traffic in both modes
        for (int mode = 0; mode < 2; mode++) begin
            do_reset(mode[0], mode[0]);
            cur_req = "R2";
            for (int k = 0; k < 2000; k++) begin
                proc_strobe_n = ($urandom_range(0, 9) != 0);
                ctrl_strobe_n = ($urandom_range(0, 9) > 3);
                adv_n = $urandom_range(0, 1) != 0;
                ce1_n = ($urandom_range(0, 7) == 0);
                ce2   = ($urandom_range(0, 7) != 0);
                ce3_n = ($urandom_range(0, 7) == 0);
                gw_n  = ($urandom_range(0, 3) != 0);
                bwe_n = $urandom_range(0, 1) != 0;
                byte_we_n = NL'($urandom);
                rv = {$urandom, $urandom};
                wdata = rv[DW-1:0];
                addr  = AW'($urandom);
                oe_n  = ($urandom_range(0, 7) == 0);
                tick();
            end
        end

        summary();
        $finish;
    end

endmodule